// File: doc/BRIEF.md
# Distributed-Arithmetic Complex Coefficient Multiplier

This block multiplies a complex data sample by a complex coefficient that is held in a register. The data sample has real part `din_re` and imaginary part `din_im`. The coefficient has real part `coef_re` and imaginary part `coef_im`. The block uses no real multipliers. When the coefficient is loaded, it is turned into two words: the difference (real − imaginary) and the sum (real + imaginary). The real and imaginary results are then formed as two separate inner products.

For every bit position of the data, two operand rows are chosen, one for each result part. The pair of data bits at that position picks either the difference word or the sum word, and also picks the sign of the row. A signed row is made by bitwise inversion, and the +1 needed to complete each negation is collected into one extra mask operand. The data sign bit inverts the sign of its row. A constant correction row completes the offset-binary sum. A carry-save chain reduces all rows to a sum vector and a carry vector. A Brent-Kung prefix adder, with its carry-in tied high, then resolves the pair into the final result. That final sum is exactly twice the product, so the output drops its least significant bit.

A data word presented with `in_valid` appears at the output one cycle later. The coefficient is reloaded whenever the surrounding logic needs a new twiddle or gain. The datapath is a single combinational stage between the coefficient register and the output register, so there is no state machine.

Top module: `da_cplx_mult`

## Requirements
- R1: When `coef_ld` is high at a rising edge, `coef_re`/`coef_im` become the coefficient used for every later sample. A sample presented with `in_valid` in the same cycle as `coef_ld` still uses the previous coefficient.
- R2: `prod_re` equals `din_re*coef_re − din_im*coef_im`, with all operands taken as signed two's-complement integers, exactly and without rounding.
- R3: `prod_im` equals `din_re*coef_im + din_im*coef_re`, with all operands taken as signed two's-complement integers, exactly and without rounding.
- R4: `out_valid` is high in the cycle after a rising edge at which `in_valid` was high, and low after an edge at which `in_valid` was low.
- R5: When `in_valid` is low at an edge, `prod_re` and `prod_im` keep their previous values, whatever `din_re`/`din_im` carry.
- R6: After reset, `out_valid`, `prod_re` and `prod_im` are zero, and the held coefficient is zero, so any sample then gives zero products.
- R7: The outputs are DATA_W+COEF_W+1 bits wide. They represent every result exactly, including the case where all four operands are at their most negative value (the imaginary result is then +2^(DATA_W+COEF_W−1)).
- R8: The sign-bit row takes the opposite sign to the other rows. As a result, data words whose sign bit alone is set (the most negative value) and data words whose sign bit alone is clear (the most positive value) both give exact results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_ld | input | 1 | Load strobe for the coefficient register |
| coef_re | input | 13 | Coefficient real part, two's complement |
| coef_im | input | 13 | Coefficient imaginary part, two's complement |
| in_valid | input | 1 | Data sample strobe |
| din_re | input | 17 | Data real part, two's complement |
| din_im | input | 17 | Data imaginary part, two's complement |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| prod_re | output | 31 | Real result, two's complement |
| prod_im | output | 31 | Imaginary result, two's complement |

## Verification
The hardest cases to reach are those that depend on the sign-bit row and on the width limit of the outputs. These are sample words at the extremes, where every data bit selects a negated row at once, and the one product that needs the full output width. Random operands almost never hit these combinations. The stimulus therefore applies directed extreme pairs, covering most negative, most positive, all-ones and alternating patterns, against extreme coefficients. It also places a coefficient load in the same cycle as a sample, to separate the register timing from the arithmetic.

// File: rtl/da_cplx_pkg.sv
package da_cplx_pkg;
    typedef enum logic {
        PART_REAL = 1'b0,
        PART_IMAG = 1'b1
    } part_e;

    localparam int DEF_DATA_W = 17;
    localparam int DEF_COEF_W = 13;
endpackage

// File: rtl/da_row_gen.sv
module da_row_gen
    import da_cplx_pkg::*;
#(
    parameter int    DATA_W = 17,
    parameter int    WORD_W = 14,
    parameter int    SUM_W  = 32,
    parameter part_e PART   = PART_REAL
) (
    input  logic [DATA_W-1:0]             bits_a,
    input  logic [DATA_W-1:0]             bits_b,
    input  logic [WORD_W-1:0]             w_diff,
    input  logic [WORD_W-1:0]             w_sum,
    output logic [DATA_W-1:0][SUM_W-1:0]  rows,
    output logic [SUM_W-1:0]              inj_mask
);
    localparam int EXT_W = SUM_W - WORD_W;

    logic [SUM_W-1:0] ext_diff;
    logic [SUM_W-1:0] ext_sum;

    assign ext_diff = {{EXT_W{w_diff[WORD_W-1]}}, w_diff};
    assign ext_sum  = {{EXT_W{w_sum[WORD_W-1]}},  w_sum};

    for (genvar k = 0; k < DATA_W; k++) begin : g_row
        logic             pick_alt;
        logic             neg_base;
        logic             neg;
        logic [SUM_W-1:0] chosen;
        logic [SUM_W-1:0] signed_word;

        assign pick_alt = bits_a[k] ^ bits_b[k];

        if (PART == PART_REAL) begin : g_real
            assign chosen   = pick_alt ? ext_sum : ext_diff;
            assign neg_base = ~bits_a[k];
        end else begin : g_imag
            assign chosen   = pick_alt ? ext_diff : ext_sum;
            assign neg_base = ~bits_b[k];
        end

        if (k == DATA_W - 1) begin : g_sign
            assign neg = ~neg_base;
        end else begin : g_mag
            assign neg = neg_base;
        end

        assign signed_word = chosen ^ {SUM_W{neg}};
        assign rows[k]     = signed_word << k;
        assign inj_mask[k] = neg;
    end

    if (SUM_W > DATA_W) begin : g_pad
        assign inj_mask[SUM_W-1:DATA_W] = '0;
    end
endmodule

// File: rtl/da_csa_chain.sv
module da_csa_chain #(
    parameter int N_OPS = 19,
    parameter int W     = 32
) (
    input  logic [N_OPS-1:0][W-1:0] ops,
    output logic [W-1:0]            sum_vec,
    output logic [W-1:0]            car_vec
);
    logic [N_OPS-1:0][W-1:0] s_st;
    logic [N_OPS-1:0][W-1:0] c_st;

    assign s_st[1] = ops[0];
    assign c_st[1] = ops[1];
    assign s_st[0] = '0;
    assign c_st[0] = '0;

    for (genvar j = 2; j < N_OPS; j++) begin : g_stage
        logic [W-1:0] maj;
        assign s_st[j] = s_st[j-1] ^ c_st[j-1] ^ ops[j];
        assign maj     = (s_st[j-1] & c_st[j-1]) | (s_st[j-1] & ops[j]) |
                         (c_st[j-1] & ops[j]);
        assign c_st[j] = {maj[W-2:0], 1'b0};
    end

    assign sum_vec = s_st[N_OPS-1];
    assign car_vec = c_st[N_OPS-1];
endmodule

// File: rtl/da_bk_adder.sv
module da_bk_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s
);
    localparam int N = 1 << $clog2(W);

    logic [N-1:0] g0;
    logic [N-1:0] p0;
    logic [N-1:0] gg;
    logic [N-1:0] pg;

    assign g0 = {{(N-W){1'b0}}, x & y};
    assign p0 = {{(N-W){1'b0}}, x ^ y};

    always_comb begin
        gg = g0;
        pg = p0;
        for (int d = 1; d < N; d = d * 2) begin
            for (int i = 2 * d - 1; i < N; i = i + 2 * d) begin
                gg[i] = gg[i] | (pg[i] & gg[i-d]);
                pg[i] = pg[i] & pg[i-d];
            end
        end
        for (int d = N / 4; d >= 1; d = d / 2) begin
            for (int i = 3 * d - 1; i < N; i = i + 2 * d) begin
                gg[i] = gg[i] | (pg[i] & gg[i-d]);
                pg[i] = pg[i] & pg[i-d];
            end
        end
    end

    always_comb begin
        s[0] = p0[0] ^ cin;
        for (int i = 1; i < W; i++) begin
            s[i] = p0[i] ^ (gg[i-1] | (pg[i-1] & cin));
        end
    end
endmodule

// File: rtl/da_cplx_mult.sv
module da_cplx_mult
    import da_cplx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int COEF_W = DEF_COEF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     coef_ld,
    input  logic [COEF_W-1:0]        coef_re,
    input  logic [COEF_W-1:0]        coef_im,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        din_re,
    input  logic [DATA_W-1:0]        din_im,
    output logic                     out_valid,
    output logic [DATA_W+COEF_W:0]   prod_re,
    output logic [DATA_W+COEF_W:0]   prod_im
);
    localparam int WORD_W = COEF_W + 1;
    localparam int OUT_W  = DATA_W + COEF_W + 1;
    localparam int SUM_W  = OUT_W + 1;
    localparam int N_OPS  = DATA_W + 2;

    // coefficient register: difference and sum words only
    logic [WORD_W-1:0] w_diff_q;
    logic [WORD_W-1:0] w_sum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_diff_q <= '0;
            w_sum_q  <= '0;
        end else if (coef_ld) begin
            w_diff_q <= {coef_re[COEF_W-1], coef_re} - {coef_im[COEF_W-1], coef_im};
            w_sum_q  <= {coef_re[COEF_W-1], coef_re} + {coef_im[COEF_W-1], coef_im};
        end
    end

    logic [SUM_W-1:0] diff_ext;
    logic [SUM_W-1:0] sum_ext;
    assign diff_ext = {{(SUM_W-WORD_W){w_diff_q[WORD_W-1]}}, w_diff_q};
    assign sum_ext  = {{(SUM_W-WORD_W){w_sum_q[WORD_W-1]}},  w_sum_q};

    logic [1:0][SUM_W-1:0] part_sum;

    for (genvar p = 0; p < 2; p++) begin : g_part
        localparam part_e PSEL = (p == 0) ? PART_REAL : PART_IMAG;

        logic [DATA_W-1:0][SUM_W-1:0] rows;
        logic [SUM_W-1:0]             inj;
        logic [SUM_W-1:0]             corr;
        logic [N_OPS-1:0][SUM_W-1:0]  ops;
        logic [SUM_W-1:0]             sv;
        logic [SUM_W-1:0]             cv;

        da_row_gen #(
            .DATA_W (DATA_W),
            .WORD_W (WORD_W),
            .SUM_W  (SUM_W),
            .PART   (PSEL)
        ) i_rows (
            .bits_a   (din_re),
            .bits_b   (din_im),
            .w_diff   (w_diff_q),
            .w_sum    (w_sum_q),
            .rows     (rows),
            .inj_mask (inj)
        );

        // correction row: negated table word, its +1 enters as adder carry-in
        if (p == 0) begin : g_corr_re
            assign corr = ~diff_ext;
        end else begin : g_corr_im
            assign corr = ~sum_ext;
        end

        for (genvar k = 0; k < DATA_W; k++) begin : g_ops
            assign ops[k] = rows[k];
        end
        assign ops[DATA_W]   = corr;
        assign ops[DATA_W+1] = inj;

        da_csa_chain #(
            .N_OPS (N_OPS),
            .W     (SUM_W)
        ) i_csa (
            .ops     (ops),
            .sum_vec (sv),
            .car_vec (cv)
        );

        da_bk_adder #(
            .W (SUM_W)
        ) i_bk (
            .x   (sv),
            .y   (cv),
            .cin (1'b1),
            .s   (part_sum[p])
        );

        // the resolved sum is twice the product: its LSB must be zero (R2, R3)
        assert_even_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (part_sum[p][0] == 1'b0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            prod_re   <= '0;
            prod_im   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prod_re <= part_sum[0][OUT_W:1];
                prod_im <= part_sum[1][OUT_W:1];
            end
        end
    end

    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid) || $past(!rst_n));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(prod_re) && $stable(prod_im)));

    assert_coef_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        coef_ld |=> (w_sum_q - w_diff_q == {$past(coef_im), 1'b0}));

    assert_coef_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_ld |=> ($stable(w_sum_q) && $stable(w_diff_q)));
endmodule

// File: tb/test_da_cplx_mult.sv
module test_da_cplx_mult;
    localparam int DW = 17;
    localparam int CW = 13;
    localparam int OW = DW + CW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          coef_ld = 1'b0;
    logic [CW-1:0] coef_re = '0;
    logic [CW-1:0] coef_im = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] din_re = '0;
    logic [DW-1:0] din_im = '0;
    logic          out_valid;
    logic [OW-1:0] prod_re;
    logic [OW-1:0] prod_im;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    longint cur_c = 0;
    longint cur_d = 0;

    always #5 clk = ~clk;

    da_cplx_mult i_da_cplx_mult (
        .clk(clk), .rst_n(rst_n), .coef_ld(coef_ld), .coef_re(coef_re),
        .coef_im(coef_im), .in_valid(in_valid), .din_re(din_re), .din_im(din_im),
        .out_valid(out_valid), .prod_re(prod_re), .prod_im(prod_im)
    );

    function automatic longint sx_d(input logic [DW-1:0] v);
        return longint'($signed(v));
    endfunction
    function automatic longint sx_c(input logic [CW-1:0] v);
        return longint'($signed(v));
    endfunction
    function automatic longint sx_o(input logic [OW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_coef(input logic [CW-1:0] c, input logic [CW-1:0] d);
        @(negedge clk);
        coef_ld = 1'b1; coef_re = c; coef_im = d; in_valid = 1'b0;
        @(negedge clk);
        coef_ld = 1'b0;
        cur_c = sx_c(c); cur_d = sx_c(d);
    endtask

    // drive one sample at a negedge, check at the following negedge
    task automatic sample(input string req, input logic [DW-1:0] a, input logic [DW-1:0] b);
        longint ea, eb;
        din_re = a; din_im = b; in_valid = 1'b1;
        ea = sx_d(a) * cur_c - sx_d(b) * cur_d;
        eb = sx_d(a) * cur_d + sx_d(b) * cur_c;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R4 valid"}, longint'(out_valid), 1);
        check({req, " R2 real"}, sx_o(prod_re), ea);
        check({req, " R3 imag"}, sx_o(prod_im), eb);
    endtask

    localparam logic [DW-1:0] DMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};
    localparam logic [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6 out_valid", longint'(out_valid), 0);
        check("R6 prod_re", sx_o(prod_re), 0);
        check("R6 prod_im", sx_o(prod_im), 0);
        rst_n = 1'b1;
        @(negedge clk);
        sample("R6 zero coefficient", 17'h0ABCD, 17'h13579);

        // R1: simple load
        load_coef(13'd100, -13'sd37);
        sample("R1 after load", 17'd5, -17'sd3);

        // R8 / R7: extremes
        load_coef(CMIN, CMIN);
        sample("R7 all most negative", DMIN, DMIN);
        check("R7 imag full width", sx_o(prod_im), 64'sd1 <<< (DW + CW - 2 + 1));
        sample("R8 min/max", DMIN, DMAX);
        sample("R8 max/min", DMAX, DMIN);
        load_coef(CMAX, CMIN);
        sample("R8 max/max", DMAX, DMAX);
        sample("R8 all ones", '1, '1);
        sample("R8 alternating", 17'h0AAAA, 17'h15555);
        load_coef(CMIN, CMAX);
        sample("R7 min/max coef", DMIN, DMAX);
        sample("R8 zero data", '0, '0);

        // R5: hold with changing data while idle
        begin
            logic [OW-1:0] hr, hi;
            hr = prod_re; hi = prod_im;
            din_re = 17'h1F0F0; din_im = 17'h00F0F; in_valid = 1'b0;
            @(negedge clk);
            check("R5 hold re", sx_o(prod_re), sx_o(hr));
            check("R5 hold im", sx_o(prod_im), sx_o(hi));
            check("R4 idle valid", longint'(out_valid), 0);
        end

        // R1: load in the same cycle as a sample uses the old coefficient
        coef_ld = 1'b1; coef_re = 13'd777; coef_im = 13'd222;
        sample("R1 same-cycle load", 17'd1000, 17'd2000);
        coef_ld = 1'b0;
        cur_c = 777; cur_d = 222;
        sample("R1 new coefficient", 17'd1000, 17'd2000);

        // random streams with random coefficient reloads
        for (int n = 0; n < 400; n++) begin
            if (n % 40 == 0) load_coef(CW'($urandom), CW'($urandom));
            sample("R2 R3 random", DW'($urandom), DW'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule